// File: doc/BRIEF.md
# Wide-Word Bus Gather/Scatter Bridge

This block sits between a 32-bit memory-mapped slave port and a processing core that consumes and produces 128-bit words. Software writes the operand as four successive 32-bit writes to one data offset. The bridge packs them into a wide input register, lowest lane first. When the last lane arrives, the bridge pulses a start strobe to the core once. The core works on that single word and signals completion with a done strobe. The bridge then latches the 128-bit result.

Software collects the result as four successive reads of the same data offset, lowest lane first. Each read returns its data one cycle later, flagged by a read-valid strobe. A status offset reports whether a result is waiting and whether the core is busy. A write of bit 0 to the status offset abandons a half-finished transfer. Bus and core share one clock.

Top module: `wide_xfer_bridge`

## Requirements
- R1: While reset is active and after it is released, both lane pointers are 0, the input and result words are all zeros, the start strobe is low, read-valid is low, and the status word reads 0.
- R2: Each write to offset 1 stores its data in the lane of the input word selected by the write pointer. The first write fills bits [31:0], then [63:32], [95:64] and [127:96].
- R3: The start strobe is high for exactly one cycle. It rises on the clock edge that accepts the fourth lane write. It never rises after only one to three lane writes.
- R4: Status bit 1 (busy) is 1 from the cycle after the start strobe until the result capture. It is 0 otherwise.
- R5: On a cycle with the core's done strobe high, the full core output is stored. Status bit 0 (result valid) then becomes 1.
- R6: A read of offset 1 returns the result lane selected by the read pointer, [31:0] first and ascending. The data appears on the read-data port one cycle after the request, with read-valid high for that one cycle.
- R7: The fourth read of offset 1 wraps the read pointer to lane 0 and clears result valid. A further read returns bits [31:0] again.
- R8: A write to offset 0 with bit 0 set returns both lane pointers to 0 and clears result valid.
- R9: The pointers move only on accesses to offset 1. Idle cycles, status reads and offset-0 writes with bit 0 clear leave both pointers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared bus and core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_addr | input | 2 | Register offset: 0 status/control, 1 data |
| bus_write | input | 1 | Write request |
| bus_read | input | 1 | Read request |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read |
| core_din | output | 128 | Packed operand to the core |
| core_start | output | 1 | One-cycle start strobe to the core |
| core_done | input | 1 | Core completion strobe |
| core_dout | input | 128 | Core result word |

## Verification
The hardest states to reach are those where a pointer sits in the middle of a word. Examples are a clear after two lane writes, or a clear after two result reads. In these states the next access must land in lane 0 and not in the lane the pointer had reached. The stimulus gets there by stopping a transfer part way. It then inserts idle cycles and status reads, issues the clear, and runs a full transfer. Any left-over pointer value would then show up as a shifted operand on the core input, or as a wrong first result lane.

// File: rtl/wxb_pkg.sv
package wxb_pkg;
  localparam int unsigned ADDR_W   = 2;
  localparam logic [ADDR_W-1:0] OFF_STAT = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFF_DATA = ADDR_W'(1);
  localparam int unsigned STAT_VALID_BIT = 0;
  localparam int unsigned STAT_BUSY_BIT  = 1;
endpackage

// File: rtl/wxb_gather.sv
module wxb_gather #(
  parameter int unsigned DW    = 32,
  parameter int unsigned LANES = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_hit,
  input  logic                clr,
  input  logic [DW-1:0]       wdata,
  output logic [DW*LANES-1:0] din,
  output logic                start
);
  localparam int unsigned PW = (LANES > 1) ? $clog2(LANES) : 1;
  localparam logic [PW-1:0] LAST = PW'(LANES - 1);

  logic [PW-1:0] wptr_q, wptr_d;
  logic          start_q, start_d;

  always_comb begin
    wptr_d  = wptr_q;
    start_d = 1'b0;
    if (clr) begin
      wptr_d = '0;
    end else if (wr_hit) begin
      if (wptr_q == LAST) begin
        wptr_d  = '0;
        start_d = 1'b1;
      end else begin
        wptr_d = wptr_q + PW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q  <= '0;
      start_q <= 1'b0;
    end else begin
      wptr_q  <= wptr_d;
      start_q <= start_d;
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic          lane_en;
    logic [DW-1:0] lane_q;
    assign lane_en = wr_hit && !clr && (wptr_q == PW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       lane_q <= '0;
      else if (lane_en) lane_q <= wdata;
    end
    assign din[i*DW +: DW] = lane_q;
  end

  assign start = start_q;

  // R3
  start_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |=> !start_q);
  // R3
  start_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(start_q) |-> $past(wr_hit));
  // R9
  wptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_hit && !clr) |=> $stable(wptr_q));
endmodule

// File: rtl/wxb_scatter.sv
module wxb_scatter #(
  parameter int unsigned DW    = 32,
  parameter int unsigned LANES = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rd_hit,
  input  logic                clr,
  input  logic                done,
  input  logic [DW*LANES-1:0] dout,
  output logic [DW-1:0]       lane_out,
  output logic                valid
);
  localparam int unsigned PW = (LANES > 1) ? $clog2(LANES) : 1;
  localparam logic [PW-1:0] LAST = PW'(LANES - 1);

  logic [DW*LANES-1:0] res_q;
  logic [PW-1:0]       rptr_q, rptr_d;
  logic                valid_q, valid_d;

  always_comb begin
    rptr_d  = rptr_q;
    valid_d = valid_q;
    if (clr) begin
      rptr_d  = '0;
      valid_d = 1'b0;
    end else begin
      if (rd_hit) begin
        if (rptr_q == LAST) begin
          rptr_d  = '0;
          valid_d = 1'b0;
        end else begin
          rptr_d = rptr_q + PW'(1);
        end
      end
      if (done) valid_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      rptr_q  <= rptr_d;
      valid_q <= valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    res_q <= '0;
    else if (done) res_q <= dout;
  end

  always_comb begin
    lane_out = '0;
    for (int i = 0; i < LANES; i++)
      if (rptr_q == PW'(i)) lane_out = res_q[i*DW +: DW];
  end

  assign valid = valid_q;

  // R5
  done_sets_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !clr) |=> valid_q);
  // R7
  valid_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(valid_q) |-> $past(clr || (rd_hit && rptr_q == LAST)));
  // R9
  rptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_hit && !clr) |=> $stable(rptr_q));
endmodule

// File: rtl/wxb_ctrl.sv
module wxb_ctrl #(
  parameter int unsigned DW = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bus_read,
  input  logic [wxb_pkg::ADDR_W-1:0] bus_addr,
  input  logic                      start,
  input  logic                      done,
  input  logic                      valid,
  input  logic [DW-1:0]             lane_out,
  output logic [DW-1:0]             rdata,
  output logic                      rvalid,
  output logic                      busy
);
  import wxb_pkg::*;

  logic          busy_q, busy_d;
  logic [DW-1:0] rdata_q, rdata_d;
  logic          rvalid_q;
  logic [DW-1:0] stat_word;

  always_comb begin
    stat_word = '0;
    stat_word[STAT_VALID_BIT] = valid;
    stat_word[STAT_BUSY_BIT]  = busy_q;
  end

  always_comb begin
    busy_d = busy_q;
    if (start)     busy_d = 1'b1;
    else if (done) busy_d = 1'b0;
  end

  always_comb begin
    rdata_d = rdata_q;
    if (bus_read) begin
      if (bus_addr == OFF_DATA)      rdata_d = lane_out;
      else if (bus_addr == OFF_STAT) rdata_d = stat_word;
      else                           rdata_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      busy_q   <= busy_d;
      rdata_q  <= rdata_d;
      rvalid_q <= bus_read;
    end
  end

  assign rdata  = rdata_q;
  assign rvalid = rvalid_q;
  assign busy   = busy_q;

  // R6
  rvalid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_read |=> rvalid_q);
  // R6
  rvalid_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_read |=> !rvalid_q);
  // R4
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(start));
endmodule

// File: rtl/wide_xfer_bridge.sv
module wide_xfer_bridge #(
  parameter int unsigned DW    = 32,
  parameter int unsigned LANES = 4,
  localparam int unsigned WW   = DW * LANES
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [wxb_pkg::ADDR_W-1:0] bus_addr,
  input  logic                       bus_write,
  input  logic                       bus_read,
  input  logic [DW-1:0]              bus_wdata,
  output logic [DW-1:0]              bus_rdata,
  output logic                       bus_rvalid,
  output logic [WW-1:0]              core_din,
  output logic                       core_start,
  input  logic                       core_done,
  input  logic [WW-1:0]              core_dout
);
  import wxb_pkg::*;

  logic          wr_hit, rd_hit, clr;
  logic [DW-1:0] lane_out;
  logic          res_valid;
  logic          busy;

  assign wr_hit = bus_write && (bus_addr == OFF_DATA);
  assign rd_hit = bus_read  && (bus_addr == OFF_DATA);
  assign clr    = bus_write && (bus_addr == OFF_STAT) && bus_wdata[0];

  wxb_gather #(.DW(DW), .LANES(LANES)) gather_i (
    .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit), .clr(clr),
    .wdata(bus_wdata), .din(core_din), .start(core_start));

  wxb_scatter #(.DW(DW), .LANES(LANES)) scatter_i (
    .clk(clk), .rst_n(rst_n), .rd_hit(rd_hit), .clr(clr),
    .done(core_done), .dout(core_dout), .lane_out(lane_out), .valid(res_valid));

  wxb_ctrl #(.DW(DW)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .bus_read(bus_read), .bus_addr(bus_addr),
    .start(core_start), .done(core_done), .valid(res_valid),
    .lane_out(lane_out), .rdata(bus_rdata), .rvalid(bus_rvalid), .busy(busy));

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (!core_start && !bus_rvalid));
  // R4
  busy_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (core_done && !core_start) |=> !busy);
endmodule

// File: tb/wide_xfer_bridge_tb_top.sv
module wide_xfer_bridge_tb_top;
  localparam int DW = 32;
  localparam int LN = 4;
  localparam int WW = DW * LN;
  localparam logic [31:0] KSTEP = 32'h0101_0101;
  localparam logic [WW-1:0] VEC [4] = '{
    {32'h0, 32'h0, 32'h0000_6464, 32'h0000_6464},
    {32'hDEAD_BEEF, 32'h1234_5678, 32'hA5A5_A5A5, 32'h0F0F_0F0F},
    {32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
    {32'h4444_4444, 32'h3333_3333, 32'h2222_2222, 32'h1111_1111}};

  logic clk = 1'b0;
  logic rst_n;
  logic [1:0] bus_addr;
  logic bus_write, bus_read;
  logic [DW-1:0] bus_wdata, bus_rdata;
  logic bus_rvalid;
  logic [WW-1:0] core_din, core_dout;
  logic core_start, core_done;
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  wide_xfer_bridge dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_write(bus_write),
    .bus_read(bus_read), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .core_din(core_din), .core_start(core_start),
    .core_done(core_done), .core_dout(core_dout));

  function automatic logic [WW-1:0] model(input logic [WW-1:0] x);
    logic [WW-1:0] r;
    for (int i = 0; i < LN; i++) r[i*DW +: DW] = x[i*DW +: DW] + KSTEP * (i + 1);
    return r;
  endfunction

  // stand-in core: done four cycles after start
  logic [2:0] cnt;
  logic [WW-1:0] held;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; core_done <= 1'b0; core_dout <= '0; held <= '0;
    end else begin
      core_done <= (cnt == 3'd1);
      if (cnt == 3'd1) core_dout <= model(held);
      if (core_start) begin cnt <= 3'd4; held <= core_din; end
      else if (cnt != 0) cnt <= cnt - 3'd1;
    end
  end

  task automatic chk(input string req, input logic [WW-1:0] act, input logic [WW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bwrite(input logic [1:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_write = 1'b1;
    @(negedge clk);
    bus_write = 1'b0;
  endtask

  task automatic bread(input logic [1:0] a, output logic [31:0] d);
    bus_addr = a; bus_read = 1'b1;
    @(negedge clk);
    bus_read = 1'b0;
    chk("R6 rvalid", WW'(bus_rvalid), WW'(1));
    d = bus_rdata;
  endtask

  task automatic wait_valid();
    logic [31:0] s;
    for (int n = 0; n < 40; n++) begin
      bread(2'd0, s);
      if (s[0]) return;
    end
    chk("R5 valid timeout", 0, 1);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [31:0] d;
    bus_addr = '0; bus_write = 0; bus_read = 0; bus_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk("R1 start", WW'(core_start), 0);
    chk("R1 din", core_din, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rvalid", WW'(bus_rvalid), 0);
    bread(2'd0, d);
    chk("R1 status", WW'(d), 0);
    bread(2'd1, d);
    chk("R1 result lane0", WW'(d), 0);
    bwrite(2'd0, 32'h1); // rewind read pointer after probe

    // table-driven full transactions
    for (int v = 0; v < 4; v++) begin
      logic [WW-1:0] exp;
      exp = model(VEC[v]);
      for (int l = 0; l < LN; l++) begin
        bwrite(2'd1, VEC[v][l*DW +: DW]);
        chk("R2 lane", WW'(core_din[l*DW +: DW]), WW'(VEC[v][l*DW +: DW]));
        chk("R3 start", WW'(core_start), WW'(l == LN - 1));
      end
      chk("R2 full word", core_din, VEC[v]);
      @(negedge clk);
      chk("R3 one cycle", WW'(core_start), 0);
      bread(2'd0, d);
      chk("R4 busy", WW'(d[1:0]), WW'(2'b10));
      wait_valid();
      bread(2'd0, d);
      chk("R4 busy clear", WW'(d[1]), 0);
      for (int l = 0; l < LN; l++) begin
        bread(2'd1, d);
        chk("R6 lane", WW'(d), WW'(exp[l*DW +: DW]));
      end
      bread(2'd0, d);
      chk("R7 valid cleared", WW'(d[0]), 0);
      if (v == 3) begin
        bread(2'd1, d);
        chk("R7 wrap lane0", WW'(d), WW'(exp[DW-1:0]));
        bwrite(2'd0, 32'h1);
      end
    end

    // R9: idle cycles, status reads and inert control writes between lanes
    bwrite(2'd1, 32'hAAAA_0001);
    bwrite(2'd1, 32'hAAAA_0002);
    repeat (5) @(negedge clk);
    bread(2'd0, d);
    bwrite(2'd0, 32'h2);
    bwrite(2'd1, 32'hAAAA_0003);
    chk("R9 lane2", WW'(core_din[95:64]), WW'(32'hAAAA_0003));
    chk("R9 no start", WW'(core_start), 0);
    bwrite(2'd1, 32'hAAAA_0004);
    chk("R9 start", WW'(core_start), 1);
    wait_valid();

    // R8: clear after two result reads and two operand writes
    bread(2'd1, d);
    bread(2'd1, d);
    bwrite(2'd1, 32'h5555_0001);
    bwrite(2'd1, 32'h5555_0002);
    bwrite(2'd0, 32'h1);
    bread(2'd0, d);
    chk("R8 valid cleared", WW'(d[0]), 0);
    for (int l = 0; l < LN; l++) bwrite(2'd1, VEC[1][l*DW +: DW]);
    chk("R8 fresh word", core_din, VEC[1]);
    wait_valid();
    bread(2'd1, d);
    chk("R8 read from lane0", WW'(d), WW'(model(VEC[1])[DW-1:0]));

    repeat (3) @(negedge clk);
    summary();
  end
endmodule